// File: doc/BRIEF.md
# Two-Wire Register Slave with Block Transfers

This block connects a two-wire SMBus to an on-chip register file. It watches the clock and data lines, detects start, repeated start and stop conditions, and acknowledges its own 7-bit device address. It then runs one of five transaction types against a register port made of an address, write data, a write strobe and a combinational read data input. The transaction types are send byte, write byte, block write, byte read and block read.

The slave keeps a 7-bit register pointer, which is loaded by the first byte after a write address. Bit 7 of that byte chooses block transfer (1) or single-byte transfer (0). During block transfers the pointer advances after each byte. A block read takes its length from register 0x00 of the attached register file. The slave drives the data line only through an open-drain pull-low enable.

Top module: `smb_reg_slave`

## Requirements
- R1: After reset the slave does not pull the data line low and does not pulse the write strobe.
- R2: The slave pulls the data line low for the acknowledge clock when the seven bits after a start equal SLAVE_ADDR (the eighth bit: 0 means write, 1 means read). When they do not match, it acknowledges nothing, writes nothing and ignores the bus until the next start.
- R3: The byte after a write address loads the pointer from bits 6:0 and the block flag from bit 7. A transaction that stops after this byte writes no register.
- R4: In single mode (bit 7 = 0) the first data byte is written at the pointer and acknowledged. Any further data byte in the same transaction is not acknowledged and not written.
- R5: In block mode (bit 7 = 1) every data byte is acknowledged and written, and the pointer advances by one after each write.
- R6: A read returns the register at the pointer, most significant bit first. The pointer and block flag set before a repeated start are kept for the read that follows.
- R7: A block read returns consecutive registers starting at the pointer. It returns at most N bytes, where N is the value of register 0x00 read when the read address is acknowledged (0 is treated as 1). After that the slave releases the line.
- R8: A master no-acknowledge ends a block read at once, even before N bytes.
- R9: A stop in any state returns the slave to idle with the line released. A start in any state begins a new address byte.
- R10: The slave changes its pull-low enable only while the clock line is low.
- R11: Each register write is a single-cycle strobe, with address and data valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | Pull data line low when 1 |
| reg_addr | output | 7 | Register file address |
| reg_wdata | output | 8 | Register write data |
| reg_we | output | 1 | Register write strobe |
| reg_rdata | input | 8 | Register read data for reg_addr, same cycle |

## Verification
The bench targets the length limit of a block read, including a count of zero and a master that keeps acknowledging after the count is spent. A slave that ignored the count would drive a fourth byte instead of letting the line float high. A master no-acknowledge after the first block byte must end the read; a design that missed it would keep driving data into the next frame. The bench also sends a second data byte in single mode, which a faulty design would write, and a wrong device address, after which any acknowledge or write points at a bad address compare. It issues a stop halfway through an address byte, and a design that did not reset there would misframe the write that follows.

// File: rtl/smb_pkg.sv
package smb_pkg;
    localparam int BYTE_W = 8;
    localparam int PTR_W  = BYTE_W - 1;
    localparam int BIT_W  = $clog2(BYTE_W);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_MACK,
        ST_TXW,
        ST_IGNORE
    } st_e;

    typedef enum logic [1:0] {
        K_ADDR,
        K_REG,
        K_WDATA
    } kind_e;

    typedef struct packed {
        st_e               st;
        kind_e             kind;
        logic [BIT_W-1:0]  bcnt;
        logic [BYTE_W-1:0] sr;
        logic [BYTE_W-1:0] tx;
        logic [PTR_W-1:0]  ptr;
        logic              blk;
        logic              rd;
        logic              wrote;
        logic              fetch;
        logic [BYTE_W-1:0] cnt;
        logic [BYTE_W-1:0] sent;
        logic              oe;
        logic              we;
        logic [BYTE_W-1:0] wdata;
    } ctl_t;
endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic scl_high2,
    output logic start_det,
    output logic stop_det
);
    localparam int LEN = STAGES + 1;

    logic [LEN-1:0] scl_sh_d, scl_sh_q;
    logic [LEN-1:0] sda_sh_d, sda_sh_q;

    always_comb begin
        scl_sh_d = {scl_sh_q[LEN-2:0], scl_i};
        sda_sh_d = {sda_sh_q[LEN-2:0], sda_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sh_q <= '1;
            sda_sh_q <= '1;
        end else begin
            scl_sh_q <= scl_sh_d;
            sda_sh_q <= sda_sh_d;
        end
    end

    logic scl_now, scl_prev, sda_now, sda_prev;
    always_comb begin
        scl_now   = scl_sh_q[LEN-2];
        scl_prev  = scl_sh_q[LEN-1];
        sda_now   = sda_sh_q[LEN-2];
        sda_prev  = sda_sh_q[LEN-1];
        sda_s     = sda_now;
        scl_rise  = scl_now & ~scl_prev;
        scl_fall  = ~scl_now & scl_prev;
        scl_high2 = scl_now & scl_prev;
        start_det = scl_high2 & sda_prev & ~sda_now;
        stop_det  = scl_high2 & ~sda_prev & sda_now;
    end
endmodule

// File: rtl/smb_slave_ctrl.sv
module smb_slave_ctrl
    import smb_pkg::*;
#(
    parameter logic [PTR_W-1:0] SLAVE_ADDR = 7'h2C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              scl_high2,
    input  logic              start_det,
    input  logic              stop_det,
    output logic              sda_oe,
    output logic [PTR_W-1:0]  reg_addr,
    output logic [BYTE_W-1:0] reg_wdata,
    output logic              reg_we,
    input  logic [BYTE_W-1:0] reg_rdata
);
    localparam logic [PTR_W-1:0]  PTR_ONE  = 1;
    localparam logic [BIT_W-1:0]  BIT_LAST = BIT_W'(BYTE_W - 1);
    localparam logic [BIT_W-1:0]  BIT_ONE  = 1;
    localparam logic [BYTE_W-1:0] BYTE_ONE = 1;

    ctl_t q, d;
    logic [BYTE_W-1:0] rx_byte;
    logic [BYTE_W-1:0] lim;

    always_comb begin
        rx_byte = {q.sr[BYTE_W-2:0], sda_s};
        lim     = (q.cnt == '0) ? BYTE_ONE : q.cnt;

        d       = q;
        d.we    = 1'b0;
        d.fetch = 1'b0;
        if (q.fetch) d.cnt = reg_rdata;
        if (q.we && q.blk) d.ptr = q.ptr + PTR_ONE;

        if (stop_det) begin
            d.st = ST_IDLE;
            d.oe = 1'b0;
        end else if (start_det) begin
            d.st    = ST_RX;
            d.kind  = K_ADDR;
            d.bcnt  = '0;
            d.oe    = 1'b0;
            d.wrote = 1'b0;
        end else begin
            case (q.st)
                ST_RX: begin
                    if (scl_rise) begin
                        d.sr   = rx_byte;
                        d.bcnt = q.bcnt + BIT_ONE;
                        if (q.bcnt == BIT_LAST) begin
                            d.bcnt = '0;
                            d.st   = ST_ACK;
                            case (q.kind)
                                K_ADDR: begin
                                    if (rx_byte[BYTE_W-1:1] == SLAVE_ADDR) begin
                                        d.rd = rx_byte[0];
                                        if (rx_byte[0]) begin
                                            d.fetch = q.blk;
                                            d.sent  = '0;
                                        end else begin
                                            d.kind = K_REG;
                                        end
                                    end else begin
                                        d.st = ST_IGNORE;
                                    end
                                end
                                K_REG: begin
                                    d.ptr   = rx_byte[PTR_W-1:0];
                                    d.blk   = rx_byte[BYTE_W-1];
                                    d.kind  = K_WDATA;
                                    d.wrote = 1'b0;
                                end
                                default: begin
                                    if (q.blk || !q.wrote) begin
                                        d.we    = 1'b1;
                                        d.wdata = rx_byte;
                                        d.wrote = 1'b1;
                                    end else begin
                                        d.st = ST_IGNORE;
                                    end
                                end
                            endcase
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_rise && q.oe && q.rd) d.tx = reg_rdata;
                    if (scl_fall) begin
                        if (!q.oe) begin
                            d.oe = 1'b1;
                        end else if (q.rd) begin
                            d.st   = ST_TX;
                            d.bcnt = '0;
                            d.oe   = ~q.tx[BYTE_W-1];
                        end else begin
                            d.st   = ST_RX;
                            d.bcnt = '0;
                            d.oe   = 1'b0;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (q.bcnt == BIT_LAST) begin
                            d.oe   = 1'b0;
                            d.st   = ST_MACK;
                            d.sent = q.sent + BYTE_ONE;
                            if (q.blk) d.ptr = q.ptr + PTR_ONE;
                        end else begin
                            d.bcnt = q.bcnt + BIT_ONE;
                            d.tx   = {q.tx[BYTE_W-2:0], 1'b0};
                            d.oe   = ~q.tx[BYTE_W-2];
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_rise) begin
                        if (!sda_s && q.blk && (q.sent < lim)) begin
                            d.tx = reg_rdata;
                            d.st = ST_TXW;
                        end else begin
                            d.st = ST_IGNORE;
                        end
                    end
                end
                ST_TXW: begin
                    if (scl_fall) begin
                        d.st   = ST_TX;
                        d.bcnt = '0;
                        d.oe   = ~q.tx[BYTE_W-1];
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, kind: K_ADDR, default: '0};
        end else begin
            q <= d;
        end
    end

    always_comb begin
        sda_oe    = q.oe;
        reg_we    = q.we;
        reg_wdata = q.wdata;
        reg_addr  = q.fetch ? '0 : q.ptr;
    end

    a_r10_oe_still_while_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_high2 && !start_det && !stop_det) |-> (d.oe == q.oe));

    a_r11_we_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        q.we |=> !q.we);

    a_r5_ptr_step_after_block_write: assert property (@(posedge clk) disable iff (!rst_n)
        (q.we && q.blk) |=> (q.ptr == $past(q.ptr) + PTR_ONE));

    a_r7_count_from_reg0: assert property (@(posedge clk) disable iff (!rst_n)
        q.fetch |=> (q.cnt == $past(reg_rdata)));

    a_r9_stop_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (q.st == ST_IDLE && !q.oe));

    a_r2_silent_when_ignoring: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IGNORE) |-> !sda_oe);
endmodule

// File: rtl/smb_reg_slave.sv
module smb_reg_slave
    import smb_pkg::*;
#(
    parameter logic [PTR_W-1:0] SLAVE_ADDR  = 7'h2C,
    parameter int               SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    output logic [PTR_W-1:0]  reg_addr,
    output logic [BYTE_W-1:0] reg_wdata,
    output logic              reg_we,
    input  logic [BYTE_W-1:0] reg_rdata
);
    logic sda_s, scl_rise, scl_fall, scl_high2, start_det, stop_det;

    smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .scl_high2 (scl_high2),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    smb_slave_ctrl #(.SLAVE_ADDR(SLAVE_ADDR)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .scl_high2 (scl_high2),
        .start_det (start_det),
        .stop_det  (stop_det),
        .sda_oe    (sda_oe),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_we    (reg_we),
        .reg_rdata (reg_rdata)
    );
endmodule

// File: tb/smb_reg_slave_test.sv
module smb_reg_slave_test;
    localparam int CLK_PERIOD = 10;
    localparam int Q = 6;
    localparam logic [7:0] AW = 8'h58;
    localparam logic [7:0] AR = 8'h59;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_low = 1'b0;
    logic sda_oe, reg_we;
    logic [6:0] reg_addr;
    logic [7:0] reg_wdata, reg_rdata;
    logic sda_line;

    int checks = 0;
    int errors = 0;
    int r10_viol = 0;

    logic [7:0] rf  [128];
    logic [7:0] mdl [128];
    logic [6:0] exp_a [$];
    logic [7:0] exp_d [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    assign sda_line  = ~(m_low | sda_oe);
    assign reg_rdata = rf[reg_addr];

    smb_reg_slave uut (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
        .sda_oe(sda_oe), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_we(reg_we), .reg_rdata(reg_rdata)
    );

    always @(posedge clk) if (reg_we) rf[reg_addr] <= reg_wdata;

    // per-clock reference comparison: writes and drive timing
    logic scl_prev = 1'b1;
    logic oe_prev = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (reg_we) begin
                checks++;
                if (exp_a.size() == 0) begin
                    errors++;
                    $display("FAIL R11 unexpected write addr=%0h data=%0h expected none", reg_addr, reg_wdata);
                end else begin
                    logic [6:0] ea;
                    logic [7:0] ed;
                    ea = exp_a.pop_front();
                    ed = exp_d.pop_front();
                    if (ea != reg_addr || ed != reg_wdata) begin
                        errors++;
                        $display("FAIL R11 write addr=%0h data=%0h expected addr=%0h data=%0h",
                                 reg_addr, reg_wdata, ea, ed);
                    end
                end
            end
            if (m_scl && scl_prev && (sda_oe != oe_prev)) r10_viol++;
        end
        scl_prev = m_scl;
        oe_prev  = sda_oe;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hold();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bstart();
        m_low = 1'b0; hold(); m_scl = 1'b1; hold();
        m_low = 1'b1; hold(); m_scl = 1'b0; hold();
    endtask

    task automatic bstop();
        m_low = 1'b1; hold(); m_scl = 1'b1; hold();
        m_low = 1'b0; hold(); hold();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            m_low = ~b[i]; hold(); m_scl = 1'b1; hold(); hold(); m_scl = 1'b0; hold();
        end
        m_low = 1'b0; hold(); m_scl = 1'b1; hold();
        ack = ~sda_line; hold(); m_scl = 1'b0; hold();
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        m_low = 1'b0;
        b = '0;
        for (int i = 0; i < 8; i++) begin
            hold(); m_scl = 1'b1; hold();
            b = {b[6:0], sda_line}; hold(); m_scl = 1'b0;
        end
        hold(); m_low = give_ack; hold(); m_scl = 1'b1; hold(); hold();
        m_scl = 1'b0; hold(); m_low = 1'b0;
    endtask

    task automatic expect_wr(input logic [6:0] a, input logic [7:0] v);
        exp_a.push_back(a);
        exp_d.push_back(v);
        mdl[a] = v;
    endtask

    task automatic single_read(input logic [6:0] a, input string req);
        logic k;
        logic [7:0] b;
        bstart(); send_byte(AW, k); send_byte({1'b0, a}, k);
        bstart(); send_byte(AR, k); chk({req, " read ack"}, k, 1);
        recv_byte(1'b0, b); chk({req, " read data"}, b, mdl[a]);
        bstop();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic k;
        logic [7:0] b;
        for (int i = 0; i < 128; i++) begin
            rf[i]  = 8'((i * 7) + 3);
            mdl[i] = 8'((i * 7) + 3);
        end
        repeat (4) @(negedge clk);
        chk("R1 oe after reset", sda_oe, 0);
        chk("R1 we after reset", reg_we, 0);
        rst_n = 1'b1;
        hold();
        chk("R1 oe idle", sda_oe, 0);

        // R4 write byte
        bstart();
        send_byte(AW, k); chk("R2 addr ack", k, 1);
        send_byte(8'h10, k); chk("R3 reg byte ack", k, 1);
        expect_wr(7'h10, 8'hA5);
        send_byte(8'hA5, k); chk("R4 data ack", k, 1);
        bstop();

        // R6 read back with repeated start
        single_read(7'h10, "R6");

        // R3 send byte only, then read without pointer byte
        bstart(); send_byte(AW, k); send_byte(8'h22, k); bstop();
        chk("R3 no write after send byte", exp_a.size(), 0);
        bstart(); send_byte(AR, k); recv_byte(1'b0, b); bstop();
        chk("R3 pointer loaded by send byte", b, mdl[7'h22]);

        // R2 wrong address
        bstart();
        send_byte(8'h5A, k); chk("R2 no ack foreign addr", k, 0);
        send_byte(8'h40, k); chk("R2 ignored byte", k, 0);
        send_byte(8'h77, k); chk("R2 ignored data", k, 0);
        bstop();
        single_read(7'h40, "R2");

        // R5 block write
        bstart(); send_byte(AW, k); send_byte(8'hB0, k);
        expect_wr(7'h30, 8'h11); send_byte(8'h11, k); chk("R5 blk ack 1", k, 1);
        expect_wr(7'h31, 8'h22); send_byte(8'h22, k); chk("R5 blk ack 2", k, 1);
        expect_wr(7'h32, 8'h33); send_byte(8'h33, k); chk("R5 blk ack 3", k, 1);
        bstop();

        // R7 count = 3, master over-acknowledges
        bstart(); send_byte(AW, k); send_byte(8'h00, k);
        expect_wr(7'h00, 8'h03); send_byte(8'h03, k); bstop();
        bstart(); send_byte(AW, k); send_byte(8'hB0, k);
        bstart(); send_byte(AR, k); chk("R7 read addr ack", k, 1);
        recv_byte(1'b1, b); chk("R7 blk byte 0", b, 8'h11);
        recv_byte(1'b1, b); chk("R7 blk byte 1", b, 8'h22);
        recv_byte(1'b1, b); chk("R7 blk byte 2", b, 8'h33);
        recv_byte(1'b0, b); chk("R7 released after count", b, 8'hFF);
        bstop();

        // R8 early no-acknowledge
        bstart(); send_byte(AW, k); send_byte(8'hB0, k);
        bstart(); send_byte(AR, k);
        recv_byte(1'b0, b); chk("R8 first byte", b, 8'h11);
        recv_byte(1'b0, b); chk("R8 released after nack", b, 8'hFF);
        bstop();

        // R7 count = 0 acts as one
        bstart(); send_byte(AW, k); send_byte(8'h00, k);
        expect_wr(7'h00, 8'h00); send_byte(8'h00, k); bstop();
        bstart(); send_byte(AW, k); send_byte(8'hB1, k);
        bstart(); send_byte(AR, k);
        recv_byte(1'b1, b); chk("R7 count0 byte", b, 8'h22);
        recv_byte(1'b0, b); chk("R7 count0 released", b, 8'hFF);
        bstop();

        // R4 extra byte in single mode
        bstart(); send_byte(AW, k); send_byte(8'h05, k);
        expect_wr(7'h05, 8'h66);
        send_byte(8'h66, k); chk("R4 first data ack", k, 1);
        send_byte(8'h99, k); chk("R4 extra data nack", k, 0);
        bstop();
        single_read(7'h05, "R4");

        // R9 stop in the middle of an address byte
        bstart();
        for (int i = 7; i >= 4; i--) begin
            m_low = ~AW[i]; hold(); m_scl = 1'b1; hold(); hold(); m_scl = 1'b0; hold();
        end
        bstop();
        chk("R9 released after stop", sda_oe, 0);
        bstart(); send_byte(AW, k); chk("R9 addr ack after abort", k, 1);
        send_byte(8'h06, k);
        expect_wr(7'h06, 8'h44); send_byte(8'h44, k); chk("R9 data ack", k, 1);
        bstop();
        single_read(7'h06, "R9");

        // R9 repeated start before data restarts address phase
        bstart(); send_byte(AW, k); send_byte(8'h07, k);
        bstart(); send_byte(AW, k); chk("R9 restart addr ack", k, 1);
        send_byte(8'h07, k);
        expect_wr(7'h07, 8'h55); send_byte(8'h55, k);
        bstop();
        single_read(7'h07, "R9");

        hold();
        chk("R11 all expected writes seen", exp_a.size(), 0);
        chk("R10 drive changes only with clock low", r10_viol, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule